// File: doc/BRIEF.md
# Byte-Lane Strobe Centering Calibrator

This block trains the strobe delay of one byte lane of a DDR4 memory interface. Data bus inversion is enabled, so the inversion line is trained together with the data lines as a ninth bit. During a calibration run the block drives a pseudo-random pattern onto the eight data lines, one byte per cycle. Each byte goes out through the DC inversion rule, so the inversion line carries values that follow from the data. The block holds each delay tap for a set number of beats and compares the captured lane against the driven lane, bit by bit.

The search first moves the tap upward from a start tap until every bit has failed or the top tap is reached. This records a right edge for each bit. It then moves downward from just below the start tap in the same way to record each left edge. The worst-case edges across all nine bits give the passing window, and the block drives its midpoint onto the tap output as the result. If any bit fails at the start tap there is no usable window, and the block raises an error flag. The per-bit edges remain readable after the run. The analog delay line and DRAM command sequencing sit outside this block.

Top module: `dqs_center_cal`

## Requirements
- R1: After reset, `tap_o`, `center_o`, both edge buses, `busy_o`, `done_o` and `err_o` are all zero.
- R2: A `start_i` pulse while not busy sets `busy_o` and clears `done_o` on the next cycle. When the run ends, `done_o` rises with `busy_o` low. `done_o`, `err_o`, `tap_o` and `center_o` then hold until the next start.
- R3: Each beat drives one byte D taken from a 23-bit LFSR (x^23+x^18+1, eight shifts per beat). If D has more than four zero bits, `dbi_n_o` is 0 and `dq_o` is ~D. Otherwise `dbi_n_o` is 1 and `dq_o` is D. As a result the lane never shows more than four zeros on `dq_o`, and at most three when `dbi_n_o` is 0.
- R4: The pattern restarts from the same seed at every tap step, so the first beat of every step equals the first beat of the run.
- R5: While searching, each tap is held for exactly `beats_i` cycles (a value of 0 counts as 1). A bit fails a step if its captured value differs from the driven value on any of those beats. Captured bit 8 is compared against `dbi_n_o`.
- R6: The right search starts at `init_tap_i` and steps up by one. The right edge of a bit is the last passing tap before its first failing tap, or the maximum tap if the bit never fails.
- R7: The left search starts at `init_tap_i`-1 and steps down by one. The left edge of a bit is the tap just above its first failing tap, or 0 if the bit never fails. When `init_tap_i` is 0, every left edge is 0 without a search.
- R8: On success the result is floor((largest left edge + smallest right edge)/2), taken over all nine bits. It appears on both `center_o` and `tap_o`, with `err_o` low.
- R9: The inversion line is bit 8 of every edge bus and takes part in the worst-case edges, so a narrower window on it alone moves the result.
- R10: If any of the nine bits fails at the start tap, the run ends with `err_o` high, and both `tap_o` and `center_o` equal `init_tap_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| init_tap_i | input | TAP_W | Tap at which the search begins |
| beats_i | input | BEAT_W | Beats compared per tap step |
| dq_o | output | 8 | Driven data lines (after inversion) |
| dbi_n_o | output | 1 | Driven inversion line, active low |
| cap_dq_i | input | 8 | Captured data lines |
| cap_dbi_n_i | input | 1 | Captured inversion line |
| tap_o | output | TAP_W | Strobe delay tap |
| busy_o | output | 1 | Calibration run in progress |
| done_o | output | 1 | Run finished, result valid |
| err_o | output | 1 | No passing window at the start tap |
| center_o | output | TAP_W | Result register |
| right_edge_o | output | 9*TAP_W | Per-bit right edges, bit b at [b*TAP_W +: TAP_W], bit 8 = inversion line |
| left_edge_o | output | 9*TAP_W | Per-bit left edges, same layout |

## Verification
The bench closes the loop with a lane model. Each of the nine bits passes only inside its own tap window and reads back inverted outside it. Uniform windows check the basic midpoint. Windows where different data bits set the right and the left limits check that the worst case is taken from each side separately. A case where only the inversion line is narrow shows that bit 8 is trained. Windows at tap 0, at the top tap, and a start tap sitting on either end separate saturation from a true edge. A window that excludes the start tap checks the error path. The driven lane is observed on every beat for the inversion rule, the per-step seed restart and the tap hold length.

// File: rtl/dqs_cal_pkg.sv
package dqs_cal_pkg;
    localparam int NBITS  = 9;
    localparam int LFSR_W = 23;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RIGHT = 3'd1,
        ST_LEFT  = 3'd2,
        ST_CALC  = 3'd3,
        ST_DONE  = 3'd4
    } cal_st_e;

    function automatic logic [LFSR_W-1:0] lfsr_adv8(input logic [LFSR_W-1:0] s);
        logic [LFSR_W-1:0] t;
        t = s;
        for (int i = 0; i < 8; i++) begin
            t = {t[LFSR_W-2:0], t[22] ^ t[17]};
        end
        return t;
    endfunction
endpackage

// File: rtl/dqs_cal_beat_gen.sv
module dqs_cal_beat_gen
    import dqs_cal_pkg::*;
(
    input  logic [LFSR_W-1:0] state_i,
    output logic [LFSR_W-1:0] next_o,
    output logic [7:0]        dq_o,
    output logic              dbi_n_o
);
    logic [7:0] raw;
    logic [3:0] zeros;

    assign raw    = state_i[7:0];
    assign next_o = lfsr_adv8(state_i);

    always_comb begin
        zeros = '0;
        for (int i = 0; i < 8; i++) begin
            zeros = zeros + {3'd0, ~raw[i]};
        end
    end

    assign dbi_n_o = (zeros > 4'd4) ? 1'b0 : 1'b1;
    assign dq_o    = dbi_n_o ? raw : ~raw;
endmodule

// File: rtl/dqs_cal_cmp.sv
module dqs_cal_cmp
    import dqs_cal_pkg::*;
(
    input  logic [7:0]       drv_dq_i,
    input  logic             drv_dbi_n_i,
    input  logic [7:0]       cap_dq_i,
    input  logic             cap_dbi_n_i,
    output logic [NBITS-1:0] miss_o
);
    logic [NBITS-1:0] drv, cap;
    assign drv = {drv_dbi_n_i, drv_dq_i};
    assign cap = {cap_dbi_n_i, cap_dq_i};

    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        assign miss_o[b] = drv[b] ^ cap[b];
    end
endmodule

// File: rtl/dqs_cal_edge_reduce.sv
module dqs_cal_edge_reduce
    import dqs_cal_pkg::*;
#(
    parameter int TAP_W = 6
) (
    input  logic [NBITS-1:0][TAP_W-1:0] left_i,
    input  logic [NBITS-1:0][TAP_W-1:0] right_i,
    output logic [TAP_W-1:0]            worst_left_o,
    output logic [TAP_W-1:0]            worst_right_o
);
    always_comb begin
        worst_left_o  = '0;
        worst_right_o = '1;
        for (int b = 0; b < NBITS; b++) begin
            if (left_i[b] > worst_left_o)   worst_left_o  = left_i[b];
            if (right_i[b] < worst_right_o) worst_right_o = right_i[b];
        end
    end
endmodule

// File: rtl/dqs_center_cal.sv
module dqs_center_cal
    import dqs_cal_pkg::*;
#(
    parameter int                TAP_W = 6,
    parameter int                BEAT_W = 8,
    parameter logic [LFSR_W-1:0] SEED  = 23'h3A5C71
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [TAP_W-1:0]       init_tap_i,
    input  logic [BEAT_W-1:0]      beats_i,
    output logic [7:0]             dq_o,
    output logic                   dbi_n_o,
    input  logic [7:0]             cap_dq_i,
    input  logic                   cap_dbi_n_i,
    output logic [TAP_W-1:0]       tap_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   err_o,
    output logic [TAP_W-1:0]       center_o,
    output logic [NBITS*TAP_W-1:0] right_edge_o,
    output logic [NBITS*TAP_W-1:0] left_edge_o
);
    localparam logic [TAP_W-1:0] TAP_MAX = '1;

    typedef struct packed {
        cal_st_e                     st;
        logic [TAP_W-1:0]            tap;
        logic [TAP_W-1:0]            init;
        logic [TAP_W-1:0]            center;
        logic [BEAT_W-1:0]           beats;
        logic [BEAT_W-1:0]           beat;
        logic [LFSR_W-1:0]           lfsr;
        logic [NBITS-1:0]            acc;
        logic [NBITS-1:0]            found;
        logic [NBITS-1:0][TAP_W-1:0] right;
        logic [NBITS-1:0][TAP_W-1:0] left;
        logic                        err;
    } regs_t;

    regs_t r_q, r_d;

    logic [LFSR_W-1:0] lfsr_next;
    logic [NBITS-1:0]  miss, fail;
    logic [TAP_W-1:0]  worst_l, worst_r;
    logic [TAP_W:0]    edge_sum;
    logic              last_beat;

    dqs_cal_beat_gen u_gen (
        .state_i (r_q.lfsr),
        .next_o  (lfsr_next),
        .dq_o    (dq_o),
        .dbi_n_o (dbi_n_o)
    );

    dqs_cal_cmp u_cmp (
        .drv_dq_i    (dq_o),
        .drv_dbi_n_i (dbi_n_o),
        .cap_dq_i    (cap_dq_i),
        .cap_dbi_n_i (cap_dbi_n_i),
        .miss_o      (miss)
    );

    dqs_cal_edge_reduce #(.TAP_W(TAP_W)) u_red (
        .left_i        (r_q.left),
        .right_i       (r_q.right),
        .worst_left_o  (worst_l),
        .worst_right_o (worst_r)
    );

    assign fail      = r_q.acc | miss;
    assign last_beat = ({1'b0, r_q.beat} + 1'b1) >= {1'b0, r_q.beats};
    assign edge_sum  = {1'b0, worst_l} + {1'b0, worst_r};

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    r_d.st    = ST_RIGHT;
                    r_d.tap   = init_tap_i;
                    r_d.init  = init_tap_i;
                    r_d.beats = beats_i;
                    r_d.beat  = '0;
                    r_d.lfsr  = SEED;
                    r_d.acc   = '0;
                    r_d.found = '0;
                    r_d.right = '0;
                    r_d.left  = '0;
                    r_d.err   = 1'b0;
                end
            end
            ST_RIGHT, ST_LEFT: begin
                r_d.lfsr = lfsr_next;
                r_d.beat = r_q.beat + 1'b1;
                r_d.acc  = fail;
                if (last_beat) begin
                    r_d.lfsr = SEED;
                    r_d.beat = '0;
                    r_d.acc  = '0;
                    if (r_q.st == ST_RIGHT) begin
                        if (r_q.tap == r_q.init && |fail) begin
                            r_d.err    = 1'b1;
                            r_d.center = r_q.init;
                            r_d.st     = ST_DONE;
                        end else begin
                            for (int b = 0; b < NBITS; b++) begin
                                if (!r_q.found[b]) begin
                                    if (fail[b]) begin
                                        r_d.right[b] = r_q.tap - 1'b1;
                                        r_d.found[b] = 1'b1;
                                    end else if (r_q.tap == TAP_MAX) begin
                                        r_d.right[b] = TAP_MAX;
                                        r_d.found[b] = 1'b1;
                                    end
                                end
                            end
                            if (&r_d.found) begin
                                if (r_q.init == '0) begin
                                    r_d.st = ST_CALC;
                                end else begin
                                    r_d.st    = ST_LEFT;
                                    r_d.tap   = r_q.init - 1'b1;
                                    r_d.found = '0;
                                end
                            end else begin
                                r_d.tap = r_q.tap + 1'b1;
                            end
                        end
                    end else begin
                        for (int b = 0; b < NBITS; b++) begin
                            if (!r_q.found[b]) begin
                                if (fail[b]) begin
                                    r_d.left[b]  = r_q.tap + 1'b1;
                                    r_d.found[b] = 1'b1;
                                end else if (r_q.tap == '0) begin
                                    r_d.left[b]  = '0;
                                    r_d.found[b] = 1'b1;
                                end
                            end
                        end
                        if (&r_d.found) r_d.st  = ST_CALC;
                        else            r_d.tap = r_q.tap - 1'b1;
                    end
                end
            end
            ST_CALC: begin
                r_d.center = edge_sum[TAP_W:1];
                r_d.tap    = edge_sum[TAP_W:1];
                r_d.st     = ST_DONE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.lfsr <= SEED;
        end else begin
            r_q <= r_d;
        end
    end

    assign tap_o        = r_q.tap;
    assign busy_o       = (r_q.st == ST_RIGHT) || (r_q.st == ST_LEFT) || (r_q.st == ST_CALC);
    assign done_o       = (r_q.st == ST_DONE);
    assign err_o        = r_q.err;
    assign center_o     = r_q.center;
    assign right_edge_o = r_q.right;
    assign left_edge_o  = r_q.left;
endmodule

// File: rtl/dqs_center_cal_chk.sv
module dqs_center_cal_chk #(
    parameter int TAP_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o,
    input logic [TAP_W-1:0] tap_o,
    input logic [TAP_W-1:0] center_o,
    input logic [7:0]       dq_o,
    input logic             dbi_n_o
);
    AST_LANE_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ($countones(~dq_o) <= (dbi_n_o ? 4 : 3)));              // R3

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));                                              // R2

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o));                     // R2

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(tap_o) && $stable(center_o) && $stable(err_o))); // R2

    AST_TAP_IS_CENTER: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (tap_o == center_o));                                   // R8

    AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);                                                 // R10
endmodule

bind dqs_center_cal dqs_center_cal_chk #(.TAP_W(TAP_W)) chk_i (.*);

// File: tb/dqs_center_cal_tb_top.sv
module dqs_center_cal_tb_top;
    localparam int TAP_W  = 6;
    localparam int BEAT_W = 8;
    localparam int NB     = 9;

    typedef struct packed {
        logic [5:0]      init;
        logic [7:0]      beats;
        logic [8:0][5:0] lo;
        logic [8:0][5:0] hi;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{init: 6'd30, beats: 8'd3, lo: {9{6'd10}}, hi: {9{6'd50}}},
        '{init: 6'd30, beats: 8'd2, lo: {6'd22, {8{6'd10}}}, hi: {6'd40, {8{6'd50}}}},
        '{init: 6'd25, beats: 8'd2, lo: {{3{6'd5}}, 6'd18, {5{6'd5}}}, hi: {{5{6'd55}}, 6'd35, {3{6'd55}}}},
        '{init: 6'd5,  beats: 8'd1, lo: {9{6'd0}},  hi: {9{6'd63}}},
        '{init: 6'd0,  beats: 8'd2, lo: {9{6'd0}},  hi: {6'd20, 6'd20, 6'd18, {6{6'd20}}}},
        '{init: 6'd63, beats: 8'd2, lo: {6'd40, 6'd44, {7{6'd40}}}, hi: {9{6'd63}}},
        '{init: 6'd10, beats: 8'd2, lo: {6'd12, {8{6'd0}}}, hi: {9{6'd30}}},
        '{init: 6'd40, beats: 8'd1, lo: {9{6'd1}},  hi: {9{6'd62}}},
        '{init: 6'd20, beats: 8'd0, lo: {{4{6'd9}}, {5{6'd11}}}, hi: {{4{6'd33}}, {5{6'd31}}}}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [TAP_W-1:0] init_tap_i = '0;
    logic [BEAT_W-1:0] beats_i = 8'd1;
    logic [7:0] dq_o, cap_dq_i;
    logic dbi_n_o, cap_dbi_n_i;
    logic [TAP_W-1:0] tap_o, center_o;
    logic busy_o, done_o, err_o;
    logic [NB*TAP_W-1:0] right_edge_o, left_edge_o;

    logic [8:0][5:0] win_lo = '0;
    logic [8:0][5:0] win_hi = '1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    dqs_center_cal #(.TAP_W(TAP_W), .BEAT_W(BEAT_W)) dut_i (.*);

    // Lane model: a bit reads back correctly only inside its tap window.
    always_comb begin
        logic [8:0] drv, cap;
        drv = {dbi_n_o, dq_o};
        for (int b = 0; b < NB; b++) begin
            cap[b] = (tap_o >= win_lo[b] && tap_o <= win_hi[b]) ? drv[b] : ~drv[b];
        end
        cap_dq_i    = cap[7:0];
        cap_dbi_n_i = cap[8];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            finish_run();
        end
    end

    task automatic run_vec(input vec_t v);
        logic [8:0] first, cur;
        int hold, lim, eff_beats;
        logic [TAP_W-1:0] prev;
        int wl, wr, ctr;
        bit exp_err;
        win_lo = v.lo;
        win_hi = v.hi;
        eff_beats = (v.beats == 0) ? 1 : int'(v.beats);
        @(negedge clk);
        init_tap_i = v.init;
        beats_i    = v.beats;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && !done_o, "R2 busy after start", int'(busy_o), 1);
        first = {dbi_n_o, dq_o};
        prev  = tap_o;
        hold  = 1;
        lim   = 0;
        while (!done_o && lim < 20000) begin
            @(negedge clk);
            lim++;
            if (busy_o && !done_o) begin
                cur = {dbi_n_o, dq_o};
                if (dbi_n_o) chk($countones(~dq_o) <= 4, "R3 zeros, inversion off", $countones(~dq_o), 4);
                else         chk($countones(~dq_o) <= 3, "R3 zeros, inversion on",  $countones(~dq_o), 3);
                if (tap_o != prev) begin
                    chk(hold == eff_beats, "R5 tap hold length", hold, eff_beats);
                    chk(cur == first, "R4 seed restart per step", int'(cur), int'(first));
                    hold = 1;
                end else begin
                    hold++;
                end
                prev = tap_o;
            end
        end
        chk(done_o && !busy_o, "R2 done at end", int'(done_o), 1);
        // expected results from the windows
        exp_err = 1'b0;
        wl = 0;
        wr = 63;
        for (int b = 0; b < NB; b++) begin
            if (v.lo[b] > v.init || v.hi[b] < v.init) exp_err = 1'b1;
            if (int'(v.lo[b]) > wl) wl = int'(v.lo[b]);
            if (int'(v.hi[b]) < wr) wr = int'(v.hi[b]);
        end
        ctr = exp_err ? int'(v.init) : (wl + wr) / 2;
        chk(err_o == exp_err, exp_err ? "R10 error flag" : "R8 error flag clear", int'(err_o), int'(exp_err));
        chk(int'(tap_o) == ctr, exp_err ? "R10 tap at start tap" : "R8 tap is center", int'(tap_o), ctr);
        chk(int'(center_o) == ctr, exp_err ? "R10 center reg" : "R8 center reg", int'(center_o), ctr);
        if (!exp_err) begin
            for (int b = 0; b < NB; b++) begin
                chk(right_edge_o[b*TAP_W +: TAP_W] == v.hi[b], (b == 8) ? "R9 inversion right edge" : "R6 right edge",
                    int'(right_edge_o[b*TAP_W +: TAP_W]), int'(v.hi[b]));
                chk(left_edge_o[b*TAP_W +: TAP_W] == v.lo[b], (v.init == 0) ? "R7 left edge, start at 0" : "R7 left edge",
                    int'(left_edge_o[b*TAP_W +: TAP_W]), int'(v.lo[b]));
            end
        end
        repeat (3) @(negedge clk);
        chk(done_o && int'(tap_o) == ctr && err_o == exp_err, "R2 result held", int'(tap_o), ctr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tap_o == 0 && center_o == 0, "R1 reset tap/center", int'(tap_o), 0);
        chk(!busy_o && !done_o && !err_o, "R1 reset flags", int'({busy_o, done_o, err_o}), 0);
        chk(right_edge_o == 0 && left_edge_o == 0, "R1 reset edges", int'(right_edge_o != 0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o, "R1 idle after reset", int'(busy_o), 0);
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end
        // back-to-back restart from done clears error
        run_vec(VECS[6]);
        run_vec(VECS[0]);
        // reset mid-run returns to the reset state
        @(negedge clk);
        init_tap_i = 6'd30;
        beats_i    = 8'd4;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy_o && !done_o && tap_o == 0, "R1 reset during run", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule